// File: doc/BRIEF.md
# Transmit Byte Queue with Empty-Threshold Flags

This block buffers outgoing bytes of a serial port ahead of the shift register. Up to `DEPTH` bytes are held in arrival order. Two kinds of writer load them: the CPU and a DMA engine, distinguished by a qualifier that comes with each write. The queue gives up one byte on each frame tick while transmission is enabled. The byte goes either to the serializer or to a loopback receiver, as a steering input selects.

Next to the data, the block keeps the status seen by the rest of the port. It keeps an occupancy count, placed in a wider count field at bit 8. It keeps a "room available" flag, set when occupancy falls to or below a threshold chosen from a small table. It keeps a "transmission ended" flag, set when the last byte has left, and an interrupt request tied to the room-available events. DMA writes clear these flags on their own, but CPU writes do not. Software can clear the flags only once the condition behind them has gone away.

Top module: `tx_threshold_fifo`

## Requirements
- R1: After reset, occupancy is 0, `flag_empty` and `flag_end` are both 1, `irq` is 0 and neither drain strobe is active.
- R2: Bytes leave in the order they were accepted. `count_field` carries the occupancy in bits starting at bit 8, and every other bit is 0.
- R3: A write while occupancy equals `DEPTH` is dropped. The byte is lost, and neither the count nor any flag changes.
- R4: A byte is removed only on a `tick` cycle with `tx_enable` high and the queue non-empty. It appears on `drain_data` in the next cycle with exactly one strobe: `ser_vld` when `loop_mode` is 0, `loop_vld` when it is 1.
- R5: `thr_sel` picks the threshold: 0 gives 8, 1 gives 4, 2 gives 2, 3 gives 1.
- R6: After a removal, if occupancy is at or below the threshold, `flag_empty` is set and, when `irq_enable` is 1, an interrupt is requested. If occupancy reaches 0, `flag_end` is also set.
- R7: An accepted DMA write (`wr_dma`=1) clears `flag_end`. If occupancy then exceeds the threshold, it also clears `flag_empty` and withdraws the interrupt. An accepted CPU write changes no flag.
- R8: A `fifo_rst` cycle empties the queue and sets both flags. It requests the interrupt when enabled. It overrides a write or a tick in the same cycle, and neither strobe follows.
- R9: A status write (`sts_wr`) with `sts_end_wr`=0 clears `flag_end` only when occupancy is 0. With `sts_empty_wr`=0, it clears `flag_empty` and withdraws the interrupt only when occupancy is above the threshold. Writing 1 to either bit has no effect.
- R10: `irq` drops in the same cycle that `irq_enable` goes low. A request pending at that time is discarded, so raising the enable again does not bring it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_dma | input | 1 | Write comes from the DMA engine (1) or the CPU (0) |
| wr_data | input | 8 | Byte to enqueue |
| tick | input | 1 | One-cycle frame tick |
| tx_enable | input | 1 | Transmission enable |
| loop_mode | input | 1 | Steer drained bytes to the loopback path |
| thr_sel | input | 2 | Empty-threshold selector |
| irq_enable | input | 1 | Transmit interrupt enable |
| fifo_rst | input | 1 | Queue reset request |
| sts_wr | input | 1 | Software status write strobe |
| sts_end_wr | input | 1 | Value written to the ended flag |
| sts_empty_wr | input | 1 | Value written to the room-available flag |
| ser_vld | output | 1 | Byte on `drain_data` goes to the serializer |
| loop_vld | output | 1 | Byte on `drain_data` goes to loopback |
| drain_data | output | 8 | Drained byte |
| count_field | output | 16 | Occupancy placed at bit 8 |
| flag_empty | output | 1 | Occupancy at or below the threshold |
| flag_end | output | 1 | Transmission ended |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its default parameters: a depth of 16 and an 8-bit data path. With these values every threshold in the table lies inside the queue, so each threshold crossing can be driven by DMA writes, and the full-queue drop is reached after sixteen writes. A scoreboard predicts every drained byte and compares it with what leaves the block. This covers the dropped seventeenth byte, the wrap of both pointers, and the loss of queued bytes on a queue reset.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [1:0] {
        THR_EIGHT = 2'd0,
        THR_FOUR  = 2'd1,
        THR_TWO   = 2'd2,
        THR_ONE   = 2'd3
    } thr_sel_e;

    typedef struct packed {
        logic room;   // occupancy at or below threshold
        logic ended;  // nothing left to send
        logic pend;   // interrupt request pending
    } txf_state_t;

    localparam txf_state_t TXF_IDLE = '{room: 1'b1, ended: 1'b1, pend: 1'b0};

    function automatic int thr_value(input thr_sel_e sel);
        case (sel)
            THR_EIGHT: return 8;
            THR_FOUR:  return 4;
            THR_TWO:   return 2;
            default:   return 1;
        endcase
    endfunction

endpackage

// File: rtl/txf_store.sv
module txf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_data = mem[rptr];
    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)) else $error("occupancy above depth"); // R3
    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH))) else $error("push into full store"); // R3
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)) else $error("clear left data behind"); // R8

endmodule

// File: rtl/txf_flags.sv
module txf_flags
    import txf_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic             push_dma,
    input  logic             pop,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr,
    input  logic             irq_en,
    input  logic             sts_wr,
    input  logic             sts_end_bit,
    input  logic             sts_room_bit,
    output txf_state_t       st
);

    txf_state_t      st_nxt;
    logic [CNT_W-1:0] count_nxt;

    assign count_nxt = count + CNT_W'(push) - CNT_W'(pop);

    always_comb begin
        st_nxt = st;
        if (clr) begin
            st_nxt.room  = 1'b1;
            st_nxt.ended = 1'b1;
            st_nxt.pend  = irq_en;
        end else begin
            // software clears take effect only once the condition is gone
            if (sts_wr) begin
                if (!sts_end_bit && count == '0) begin
                    st_nxt.ended = 1'b0;
                end
                if (!sts_room_bit && count > thr) begin
                    st_nxt.room = 1'b0;
                    st_nxt.pend = 1'b0;
                end
            end
            if (push && push_dma) begin
                st_nxt.ended = 1'b0;
                if (count_nxt > thr) begin
                    st_nxt.room = 1'b0;
                    st_nxt.pend = 1'b0;
                end
            end
            if (pop) begin
                if (count_nxt <= thr) begin
                    st_nxt.room = 1'b1;
                    if (irq_en) st_nxt.pend = 1'b1;
                end
                if (count_nxt == '0) begin
                    st_nxt.ended = 1'b1;
                end
            end
        end
        if (!irq_en) begin
            st_nxt.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= TXF_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    AST_DMA_CLEARS_END: assert property (@(posedge clk) disable iff (rst)
        (push && push_dma && !clr) |=> !st.ended) else $error("DMA write left end set"); // R7
    AST_DRAIN_SETS_ROOM: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr && count_nxt <= thr) |=> st.room) else $error("drain below threshold left flag clear"); // R6
    AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(st.ended) |-> (count == '0)) else $error("end flag rose with data queued"); // R6
    AST_RESET_SETS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st.room && st.ended)) else $error("queue reset did not set flags"); // R8

endmodule

// File: rtl/tx_threshold_fifo.sv
module tx_threshold_fifo
    import txf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int CNT_LSB = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_dma,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               tick,
    input  logic               tx_enable,
    input  logic               loop_mode,
    input  logic [1:0]         thr_sel,
    input  logic               irq_enable,
    input  logic               fifo_rst,
    input  logic               sts_wr,
    input  logic               sts_end_wr,
    input  logic               sts_empty_wr,
    output logic               ser_vld,
    output logic               loop_vld,
    output logic [DATA_W-1:0]  drain_data,
    output logic [FIELD_W-1:0] count_field,
    output logic               flag_empty,
    output logic               flag_end,
    output logic               irq
);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  thr;
    logic [DATA_W-1:0] head;
    logic              full;
    logic              empty;
    logic              push;
    logic              pop;
    txf_state_t        st;

    assign thr  = CNT_W'(thr_value(thr_sel_e'(thr_sel)));
    assign push = wr_en && !full && !fifo_rst;
    assign pop  = tick && tx_enable && !empty && !fifo_rst;

    txf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (fifo_rst),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head),
        .count     (cnt),
        .full      (full),
        .empty     (empty)
    );

    txf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .clr          (fifo_rst),
        .push         (push),
        .push_dma     (wr_dma),
        .pop          (pop),
        .count        (cnt),
        .thr          (thr),
        .irq_en       (irq_enable),
        .sts_wr       (sts_wr),
        .sts_end_bit  (sts_end_wr),
        .sts_room_bit (sts_empty_wr),
        .st           (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_vld    <= 1'b0;
            loop_vld   <= 1'b0;
            drain_data <= '0;
        end else begin
            ser_vld  <= pop && !loop_mode;
            loop_vld <= pop && loop_mode;
            if (pop) drain_data <= head;
        end
    end

    assign count_field = FIELD_W'(cnt) << CNT_LSB;
    assign flag_empty  = st.room;
    assign flag_end    = st.ended;
    assign irq         = st.pend && irq_enable;

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cnt == CNT_W'(DEPTH) && !pop && !fifo_rst) |=> (cnt == CNT_W'(DEPTH)))
        else $error("write into full queue changed count"); // R3
    AST_NO_DRAIN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !(ser_vld || loop_vld)) else $error("drain while disabled"); // R4
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ser_vld, loop_vld})) else $error("both drain paths strobed"); // R4

endmodule

// File: tb/tx_threshold_fifo_bench.sv
module tx_threshold_fifo_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_dma, tick, tx_enable, loop_mode, irq_enable;
    logic        fifo_rst, sts_wr, sts_end_wr, sts_empty_wr;
    logic [7:0]  wr_data;
    logic [1:0]  thr_sel;
    logic        ser_vld, loop_vld, flag_empty, flag_end, irq;
    logic [7:0]  drain_data;
    logic [15:0] count_field;

    int nchk = 0;
    int nfail = 0;
    int m_cnt = 0;
    logic [7:0] exp_q[$];
    logic [7:0] mon_e;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_threshold_fifo u_tx_threshold_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dma(wr_dma), .wr_data(wr_data),
        .tick(tick), .tx_enable(tx_enable), .loop_mode(loop_mode), .thr_sel(thr_sel),
        .irq_enable(irq_enable), .fifo_rst(fifo_rst), .sts_wr(sts_wr),
        .sts_end_wr(sts_end_wr), .sts_empty_wr(sts_empty_wr), .ser_vld(ser_vld),
        .loop_vld(loop_vld), .drain_data(drain_data), .count_field(count_field),
        .flag_empty(flag_empty), .flag_end(flag_end), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int thr_of(input int s);
        case (s)
            0: return 8;
            1: return 4;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    // monitor: compares every drained byte with the scoreboard (R2)
    always @(negedge clk) begin
        if (ser_vld === 1'b1 || loop_vld === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected drained byte", 32'(drain_data), 32'hFFFF_FFFF);
            end else begin
                mon_e = exp_q.pop_front();
                chk("R2 drain order", 32'(drain_data), 32'(mon_e));
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_wr(input logic [7:0] b, input logic dma);
        wr_en = 1'b1; wr_dma = dma; wr_data = b;
        if (m_cnt < DEPTH) begin
            exp_q.push_back(b);
            m_cnt++;
        end
        step();
        wr_en = 1'b0; wr_dma = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        if (tx_enable && m_cnt > 0) m_cnt--;
        step();
        tick = 1'b0;
    endtask

    task automatic do_frst();
        fifo_rst = 1'b1;
        step();
        fifo_rst = 1'b0;
        exp_q.delete();
        m_cnt = 0;
    endtask

    task automatic do_sts(input logic e_end, input logic e_empty);
        sts_wr = 1'b1; sts_end_wr = e_end; sts_empty_wr = e_empty;
        step();
        sts_wr = 1'b0; sts_end_wr = 1'b1; sts_empty_wr = 1'b1;
    endtask

    task automatic drain_all();
        tx_enable = 1'b1;
        while (m_cnt > 0) do_tick();
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_dma = 0; wr_data = 0; tick = 0; tx_enable = 0;
        loop_mode = 0; thr_sel = 2'd0; irq_enable = 0; fifo_rst = 0;
        sts_wr = 0; sts_end_wr = 1; sts_empty_wr = 1;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 count", 32'(count_field), 0);
        chk("R1 empty flag", 32'(flag_empty), 1);
        chk("R1 end flag", 32'(flag_end), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 strobes", 32'({ser_vld, loop_vld}), 0);

        irq_enable = 1'b1;
        // R7 CPU writes leave flags alone; R2 count field
        do_wr(8'h11, 1'b0); do_wr(8'h22, 1'b0); do_wr(8'h33, 1'b0);
        chk("R2 count field", 32'(count_field), 32'(3 << 8));
        chk("R7 cpu write keeps empty", 32'(flag_empty), 1);
        chk("R7 cpu write keeps end", 32'(flag_end), 1);

        // R4 tick with transmit disabled does nothing
        do_tick();
        chk("R4 no strobe when disabled", 32'({ser_vld, loop_vld}), 0);
        chk("R4 count held when disabled", 32'(count_field), 32'(3 << 8));

        // R4 / R6 drain to serializer
        tx_enable = 1'b1;
        do_tick();
        chk("R4 ser strobe", 32'({ser_vld, loop_vld}), 32'b10);
        chk("R6 empty after drain", 32'(flag_empty), 1);
        chk("R6 irq after drain", 32'(irq), 1);
        do_tick(); do_tick();
        chk("R6 end at zero", 32'(flag_end), 1);
        chk("R2 count zero", 32'(count_field), 0);
        do_tick();
        chk("R4 no strobe on empty tick", 32'({ser_vld, loop_vld}), 0);

        // R7 DMA writes
        tx_enable = 1'b0;
        do_wr(8'h40, 1'b1);
        chk("R7 dma clears end", 32'(flag_end), 0);
        chk("R7 dma keeps empty at low fill", 32'(flag_empty), 1);
        for (int i = 1; i < 8; i++) do_wr(8'(8'h40 + i), 1'b1);
        chk("R7 empty held at threshold", 32'(flag_empty), 1);
        do_wr(8'h48, 1'b1);
        chk("R7 dma above threshold clears empty", 32'(flag_empty), 0);
        chk("R7 dma above threshold withdraws irq", 32'(irq), 0);

        // R4 loopback path, R6 equality boundary
        tx_enable = 1'b1; loop_mode = 1'b1;
        do_tick();
        chk("R4 loop strobe", 32'({ser_vld, loop_vld}), 32'b01);
        chk("R6 empty at equal threshold", 32'(flag_empty), 1);
        chk("R6 irq at equal threshold", 32'(irq), 1);
        loop_mode = 1'b0;
        drain_all();
        chk("R6 end after full drain", 32'(flag_end), 1);

        // R5 threshold table
        tx_enable = 1'b0;
        for (int s = 0; s < 4; s++) begin
            int first;
            first = 0;
            thr_sel = 2'(s);
            do_frst();
            for (int k = 1; k <= 9; k++) begin
                do_wr(8'(k + s * 16), 1'b1);
                if (first == 0 && flag_empty == 1'b0) first = k;
            end
            chk("R5 threshold", 32'(first), 32'(thr_of(s) + 1));
            drain_all();
            tx_enable = 1'b0;
        end

        // R3 write to full queue
        thr_sel = 2'd0;
        do_frst();
        for (int i = 0; i < 17; i++) do_wr(8'(8'hA0 + i), 1'b0);
        chk("R3 count stops at depth", 32'(count_field), 32'(16 << 8));
        chk("R3 no flag change", 32'({flag_empty, flag_end}), 32'b11);
        drain_all();
        chk("R3 queue drained", 32'(count_field), 0);

        // R8 queue reset overrides write and tick
        tx_enable = 1'b0;
        for (int i = 0; i < 10; i++) do_wr(8'(8'h60 + i), 1'b1);
        chk("R8 precondition flags clear", 32'({flag_empty, flag_end}), 0);
        tx_enable = 1'b1;
        fifo_rst = 1'b1; wr_en = 1'b1; wr_data = 8'hEE; tick = 1'b1;
        step();
        fifo_rst = 1'b0; wr_en = 1'b0; tick = 1'b0;
        exp_q.delete(); m_cnt = 0;
        chk("R8 count cleared", 32'(count_field), 0);
        chk("R8 flags set", 32'({flag_empty, flag_end}), 32'b11);
        chk("R8 irq requested", 32'(irq), 1);
        chk("R8 no strobe", 32'({ser_vld, loop_vld}), 0);
        tx_enable = 1'b0;

        // R10 enable gating
        irq_enable = 1'b0;
        #1;
        chk("R10 irq drops at once", 32'(irq), 0);
        step();
        irq_enable = 1'b1;
        #1;
        chk("R10 no stale irq", 32'(irq), 0);

        // R9 software status writes
        do_frst();
        do_wr(8'h71, 1'b0);
        do_sts(1'b0, 1'b1);
        chk("R9 end clear ignored when non-empty", 32'(flag_end), 1);
        do_sts(1'b1, 1'b0);
        chk("R9 empty clear ignored at low fill", 32'(flag_empty), 1);
        for (int i = 0; i < 8; i++) do_wr(8'(8'h72 + i), 1'b0);
        chk("R9 irq pending before clear", 32'(irq), 1);
        do_sts(1'b1, 1'b0);
        chk("R9 empty cleared above threshold", 32'(flag_empty), 0);
        chk("R9 irq withdrawn", 32'(irq), 0);
        drain_all();
        do_sts(1'b1, 1'b1);
        chk("R9 writing ones no effect", 32'({flag_empty, flag_end}), 32'b11);
        do_sts(1'b0, 1'b1);
        chk("R9 end cleared when empty", 32'(flag_end), 0);

        step();
        chk("R2 scoreboard empty", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule